// File: doc/BRIEF.md
# Compressed-Audio Burst Header Detector

This block sits behind a digital-audio receiver and decides whether the incoming subframes carry compressed data instead of linear PCM. Each accepted subframe contributes one 16-bit payload word, taken from a fixed bit field of the subframe. The block searches the word stream for a six-word synchronisation pattern. The two words that follow the pattern are the burst header: a burst-information word, whose low bits name the payload type, and a burst-length word. The block latches both words and pulses an update strobe.

A separate frame strobe advances a timeout counter. Each complete header restarts the counter. If the count of frames since the last header reaches the timeout limit, the detection flag drops and both header outputs return to zero. Compressed formats repeat their header every few thousand frames or less: 1536 for one common surround codec and 1152 for a common layered codec. A limit of 4096 frames therefore keeps the flag steady while a stream plays and drops it soon after the stream stops. The searcher can also be built without zero-overlap resynchronisation, and the payload field position and the timeout limit are parameters.

Top module: `nonpcm_burst_detector`

## Requirements
- R1: The payload word is bits [27:12] of `sub_word`. The other bits of `sub_word` do not affect any output.
- R2: A header is recognised only when six consecutive accepted words (`sub_valid` high) equal 0x0000, 0x0000, 0x0000, 0x0000, 0xF872 and 0x4E1F in that order. Cycles with `sub_valid` low neither advance nor break the search.
- R3: When a word mismatches partway through the pattern, a zero word still counts toward the leading zeros. A run of more than four zeros followed by 0xF872, 0x4E1F is therefore recognised, and so is the pattern starting at a zero that breaks an earlier attempt.
- R4: The first accepted word after 0x4E1F is the burst-information value and the second is the burst-length value. In the cycle after the burst-length word is accepted, `hdr_update` is 1, `stream_flag` is 1, `burst_pc` holds the first value and `burst_pd` holds the second.
- R5: The two header words are not searched for the pattern. Searching restarts from an empty history with the word after the burst-length word.
- R6: The block counts `frame_start` pulses since the last header. When the count reaches TIMEOUT_FRAMES (default 4096), `stream_flag`, `burst_pc` and `burst_pd` are 0 from the next cycle on.
- R7: The frame count stops at the limit instead of wrapping. A new header restarts the count from zero. A `frame_start` in the same cycle as a burst-length word is not counted.
- R8: After reset, all four outputs are 0.
- R9: `hdr_update` is high for exactly one cycle per recognised header.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | `sub_word` holds an accepted subframe this cycle |
| frame_start | input | 1 | One-cycle pulse per received frame, advances the timeout |
| sub_word | input | SUB_W (32) | Received subframe; payload at bits [27:12] |
| stream_flag | output | 1 | Compressed stream present |
| burst_pc | output | 16 | Last burst-information word, 0 when no stream |
| burst_pd | output | 16 | Last burst-length word, 0 when no stream |
| hdr_update | output | 1 | One-cycle strobe when a new header is latched |

## Verification
On every cycle, the assertions check that the update strobe never lasts two cycles, that the flag rises only together with an update, and that the header outputs are zero whenever the flag is low. They also check that the search position stays in range and idles while header words are being taken, and that the frame counter stays within its limit and is cleared after a header. Only the bench's scenarios can show the search behaviour itself. These scenarios cover which word sequences count as a pattern, including the overlap of extra zeros and the exclusion of header words, and the exact frame on which the timeout fires. They also show that unrelated subframe bits are ignored and that a header and a frame pulse in the same cycle interact as stated.

// File: rtl/nonpcm_pkg.sv
package nonpcm_pkg;

   localparam int PAYLOAD_W = 16;
   localparam int SYNC_LEN  = 6;

   typedef enum logic [1:0] {
      CAP_HUNT = 2'd0,
      CAP_PC   = 2'd1,
      CAP_PD   = 2'd2
   } cap_state_t;

   // Expected payload word at a given position of the sync pattern
   function automatic logic [PAYLOAD_W-1:0] sync_word(input logic [2:0] pos);
      case (pos)
         3'd4:    sync_word = 16'hF872;
         3'd5:    sync_word = 16'h4E1F;
         default: sync_word = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/nonpcm_sync_matcher.sv
module nonpcm_sync_matcher
   import nonpcm_pkg::*;
#(
   parameter bit ZERO_RESYNC = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 word_vld,
   input  logic [PAYLOAD_W-1:0] word,
   output logic                 hit,
   output logic [PAYLOAD_W-1:0] pc_hold
);

   localparam logic [2:0] LAST_POS = 3'(SYNC_LEN - 1);

   cap_state_t mode;
   logic [2:0] pos;
   logic [2:0] miss_pos;

   generate
      if (ZERO_RESYNC) begin : g_overlap
         // A zero word that breaks the match still counts as a leading zero
         always_comb begin
            if (word != '0)
               miss_pos = 3'd0;
            else if (pos == 3'd4)
               miss_pos = 3'd4;
            else
               miss_pos = 3'd1;
         end
      end else begin : g_strict
         assign miss_pos = 3'd0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= CAP_HUNT;
         pos     <= 3'd0;
         pc_hold <= '0;
      end else if (word_vld) begin
         case (mode)
            CAP_HUNT: begin
               if (word == sync_word(pos)) begin
                  if (pos == LAST_POS) begin
                     mode <= CAP_PC;
                     pos  <= 3'd0;
                  end else begin
                     pos <= pos + 3'd1;
                  end
               end else begin
                  pos <= miss_pos;
               end
            end
            CAP_PC: begin
               pc_hold <= word;
               mode    <= CAP_PD;
            end
            default: mode <= CAP_HUNT;
         endcase
      end
   end

   assign hit = word_vld && (mode == CAP_PD);

   p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pos <= LAST_POS);

   p_no_search_in_header_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != CAP_HUNT) |-> (pos == 3'd0));

   p_pd_returns_to_hunt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (mode == CAP_HUNT));

endmodule

// File: rtl/nonpcm_frame_timer.sv
module nonpcm_frame_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic frame_tick,
   output logic expire
);

   localparam int               CNT_W   = $clog2(LIMIT + 1);
   localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (frame_tick && (cnt != LIMIT_C))
         cnt <= cnt + 1'b1;
   end

   assign expire = frame_tick && !restart && (cnt == LAST_C);

   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIMIT_C);

   p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LIMIT_C && !restart) |=> (cnt == LIMIT_C));

endmodule

// File: rtl/nonpcm_burst_detector.sv
module nonpcm_burst_detector
   import nonpcm_pkg::*;
#(
   parameter int SUB_W          = 32,
   parameter int DATA_LSB       = 12,
   parameter int TIMEOUT_FRAMES = 4096,
   parameter bit ZERO_RESYNC    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sub_valid,
   input  logic                 frame_start,
   input  logic [SUB_W-1:0]     sub_word,
   output logic                 stream_flag,
   output logic [PAYLOAD_W-1:0] burst_pc,
   output logic [PAYLOAD_W-1:0] burst_pd,
   output logic                 hdr_update
);

   localparam int DATA_MSB = DATA_LSB + PAYLOAD_W - 1;

   generate
      if (DATA_LSB < 1 || DATA_MSB >= SUB_W - 1) begin : g_bad_field
         $error("payload field must leave bits free on both sides of the subframe");
      end
      if (TIMEOUT_FRAMES < 2) begin : g_bad_timeout
         $error("TIMEOUT_FRAMES must be at least 2");
      end
   endgenerate

   logic [PAYLOAD_W-1:0] payload;
   logic                 unused_sub_bits;
   logic                 hit;
   logic                 expire;
   logic [PAYLOAD_W-1:0] pc_hold;

   assign payload         = sub_word[DATA_MSB:DATA_LSB];
   assign unused_sub_bits = ^{sub_word[SUB_W-1:DATA_MSB+1], sub_word[DATA_LSB-1:0]};

   nonpcm_sync_matcher #(
      .ZERO_RESYNC (ZERO_RESYNC)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .word_vld (sub_valid),
      .word     (payload),
      .hit      (hit),
      .pc_hold  (pc_hold)
   );

   nonpcm_frame_timer #(
      .LIMIT (TIMEOUT_FRAMES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (hit),
      .frame_tick (frame_start),
      .expire     (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stream_flag <= 1'b0;
         burst_pc    <= '0;
         burst_pd    <= '0;
         hdr_update  <= 1'b0;
      end else begin
         hdr_update <= hit;
         if (hit) begin
            stream_flag <= 1'b1;
            burst_pc    <= pc_hold;
            burst_pd    <= payload;
         end else if (expire) begin
            stream_flag <= 1'b0;
            burst_pc    <= '0;
            burst_pd    <= '0;
         end
      end
   end

   p_update_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_update |-> stream_flag);

   p_rise_with_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stream_flag) |-> hdr_update);

   p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stream_flag |-> (burst_pc == '0 && burst_pd == '0));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_update |=> !hdr_update);

endmodule

// File: tb/nonpcm_burst_detector_test.sv
module nonpcm_burst_detector_test;

   localparam int LIMIT = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sub_valid = 1'b0;
   logic        frame_start = 1'b0;
   logic [31:0] sub_word = '0;
   logic        stream_flag;
   logic [15:0] burst_pc;
   logic [15:0] burst_pd;
   logic        hdr_update;

   nonpcm_burst_detector uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sub_valid   (sub_valid),
      .frame_start (frame_start),
      .sub_word    (sub_word),
      .stream_flag (stream_flag),
      .burst_pc    (burst_pc),
      .burst_pd    (burst_pd),
      .hdr_update  (hdr_update)
   );

   always #10 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;

   // Reference state, derived from the requirements
   logic [15:0] win [6];
   int          nwin;
   int          cap;       // 0 searching, 1 expect info word, 2 expect length word
   logic [15:0] m_tmp;
   logic        m_flag, m_upd;
   logic [15:0] m_pc, m_pd;
   int          m_cnt;
   int          upd_seen;

   function automatic bit window_is_sync();
      return nwin == 6 && win[0] == 16'h0 && win[1] == 16'h0 && win[2] == 16'h0 &&
             win[3] == 16'h0 && win[4] == 16'hF872 && win[5] == 16'h4E1F;
   endfunction

   task automatic model_reset();
      nwin = 0; cap = 0; m_tmp = '0;
      m_flag = 0; m_upd = 0; m_pc = '0; m_pd = '0; m_cnt = 0;
      for (int i = 0; i < 6; i++) win[i] = '0;
   endtask

   task automatic model_step(bit v, logic [15:0] w, bit fs);
      bit hit = 0;
      if (v) begin
         if (cap == 2) begin
            hit = 1; cap = 0; nwin = 0;
         end else if (cap == 1) begin
            m_tmp = w; cap = 2;
         end else begin
            for (int i = 0; i < 5; i++) win[i] = win[i+1];
            win[5] = w;
            if (nwin < 6) nwin++;
            if (window_is_sync()) begin
               cap = 1; nwin = 0;
            end
         end
      end
      m_upd = hit;
      if (hit) begin
         m_flag = 1; m_pc = m_tmp; m_pd = w; m_cnt = 0;
      end else if (fs && m_cnt < LIMIT) begin
         m_cnt++;
         if (m_cnt == LIMIT) begin
            m_flag = 0; m_pc = '0; m_pd = '0;
         end
      end
   endtask

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(string tag);
      check(tag, "stream_flag", 32'(stream_flag), 32'(m_flag));
      check(tag, "burst_pc",    32'(burst_pc),    32'(m_pc));
      check(tag, "burst_pd",    32'(burst_pd),    32'(m_pd));
      check(tag, "hdr_update",  32'(hdr_update),  32'(m_upd));
      if (hdr_update === 1'b1) upd_seen++;
   endtask

   // Drive one cycle at a falling edge, check at the next falling edge
   task automatic drive(bit v, logic [15:0] w, bit fs, string tag);
      logic [31:0] junk = $urandom;
      sub_valid   = v;
      frame_start = fs;
      sub_word    = {junk[31:28], w, junk[11:0]};
      model_step(v, w, fs);
      @(negedge clk);
      sub_valid   = 1'b0;
      frame_start = 1'b0;
      compare_all(tag);
   endtask

   task automatic send_sync(string tag);
      drive(1, 16'h0000, 0, tag);
      drive(1, 16'h0000, 0, tag);
      drive(1, 16'h0000, 0, tag);
      drive(1, 16'h0000, 0, tag);
      drive(1, 16'hF872, 0, tag);
      drive(1, 16'h4E1F, 0, tag);
   endtask

   task automatic send_burst(logic [15:0] pc, logic [15:0] pd, bit fs_last, string tag);
      send_sync(tag);
      drive(1, pc, 0, tag);
      drive(1, pd, fs_last, tag);
   endtask

   task automatic frames(int n, string tag);
      for (int i = 0; i < n; i++) drive(0, 16'($urandom), 1, tag);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R8: reset state
      compare_all("R8");
      check("R8", "flag after reset", 32'(stream_flag), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R8");

      // R1: header with junk outside the payload field
      send_burst(16'h0015, 16'h1800, 0, "R1");
      check("R1", "pc value", 32'(burst_pc), 32'h0015);
      check("R1", "pd value", 32'(burst_pd), 32'h1800);
      check("R4", "update", 32'(hdr_update), 32'd1);
      drive(0, 16'h0, 0, "R9");
      check("R9", "update drops", 32'(hdr_update), 32'd0);

      // R2: gaps with sync-looking data while sub_valid is low
      drive(1, 16'h0000, 0, "R2");
      drive(0, 16'hF872, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(0, 16'h4E1F, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(1, 16'hF872, 0, "R2");
      drive(0, 16'h0000, 0, "R2");
      drive(1, 16'h4E1F, 0, "R2");
      drive(1, 16'h0001, 0, "R2");
      drive(1, 16'h2000, 0, "R2");
      check("R2", "gapped header pc", 32'(burst_pc), 32'h0001);
      // R2: only three zeros -> no header
      upd_seen = 0;
      drive(1, 16'h1234, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(1, 16'h0000, 0, "R2");
      drive(1, 16'hF872, 0, "R2");
      drive(1, 16'h4E1F, 0, "R2");
      drive(1, 16'h0003, 0, "R2");
      drive(1, 16'h0004, 0, "R2");
      check("R2", "short pattern ignored", 32'(upd_seen), 32'd0);

      // R3: extra leading zeros, and restart at a breaking zero
      for (int i = 0; i < 6; i++) drive(1, 16'h0000, 0, "R3");
      drive(1, 16'hF872, 0, "R3");
      drive(1, 16'h4E1F, 0, "R3");
      drive(1, 16'h000B, 0, "R3");
      drive(1, 16'h0100, 0, "R3");
      check("R3", "long zero run pc", 32'(burst_pc), 32'h000B);
      for (int i = 0; i < 4; i++) drive(1, 16'h0000, 0, "R3");
      drive(1, 16'hF872, 0, "R3");
      send_burst(16'h0007, 16'h0777, 0, "R3");
      check("R3", "overlap restart pd", 32'(burst_pd), 32'h0777);

      // R5: zero header words are not part of the next search
      upd_seen = 0;
      send_burst(16'h0000, 16'h0000, 0, "R5");
      drive(1, 16'h0000, 0, "R5");
      drive(1, 16'h0000, 0, "R5");
      drive(1, 16'hF872, 0, "R5");
      drive(1, 16'h4E1F, 0, "R5");
      drive(1, 16'h0009, 0, "R5");
      drive(1, 16'h0009, 0, "R5");
      check("R5", "header words excluded", 32'(upd_seen), 32'd1);

      // R6: timeout at the 4096th frame
      send_burst(16'h0001, 16'h3000, 0, "R6");
      frames(LIMIT - 1, "R6");
      check("R6", "flag before limit", 32'(stream_flag), 32'd1);
      frames(1, "R6");
      check("R6", "flag at limit", 32'(stream_flag), 32'd0);
      check("R6", "pc cleared", 32'(burst_pc), 32'd0);
      check("R6", "pd cleared", 32'(burst_pd), 32'd0);

      // R7: saturation, restart, and frame pulse alongside the length word
      frames(20, "R7");
      send_burst(16'h0005, 16'h2400, 1, "R7");
      check("R7", "flag back", 32'(stream_flag), 32'd1);
      frames(LIMIT - 1, "R7");
      check("R7", "same-cycle frame not counted", 32'(stream_flag), 32'd1);
      frames(1, "R7");
      check("R7", "expires after full count", 32'(stream_flag), 32'd0);
      // periodic headers every 1536 frames keep the flag high
      for (int k = 0; k < 3; k++) begin
         send_burst(16'h0001, 16'h1800, 0, "R7");
         frames(1536, "R7");
         check("R7", "periodic flag", 32'(stream_flag), 32'd1);
      end

      // Random mix against the reference model
      for (int k = 0; k < 4000; k++) begin
         int r = int'($urandom % 10);
         bit fs = ($urandom % 8) == 0;
         case (r)
            0: begin
               for (int z = 0; z < int'($urandom % 3); z++) drive(1, 16'h0, fs, "R2");
               send_burst(16'($urandom), 16'($urandom), fs, "R4");
            end
            1, 2, 3: drive(1, 16'h0000, fs, "R3");
            4:       drive(1, 16'hF872, fs, "R2");
            5:       drive(1, 16'h4E1F, fs, "R2");
            6:       drive(0, 16'($urandom), fs, "R2");
            default: drive(1, 16'($urandom), fs, "R1");
         endcase
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule